// File: doc/BRIEF.md
# Jitter Attenuator Elastic Bit FIFO

This block is a bit-serial elastic store placed in either the transmit or the receive data path of a line interface. Bits arrive on a write strobe derived from the line clock. They leave on a read strobe that a separate smoothing loop produces. The store absorbs the phase wander between the two strobes, so the output stream follows the dejittered timing. The path not chosen passes through untouched.

A 2-bit size field sets the usable depth to 16, 32 or 128 bits, or switches the attenuator off so that both paths pass straight through. The store watches its fill level and raises a latched limit alarm when it comes within two bits of either end. A status-read pulse clears the alarm and recentres the store. Recentring, which also follows reset and any change of size or path, places the fill level at half the selected depth, with zeros in the preloaded slots.

Everything runs in one system clock domain. Writes and reads are single-cycle enable strobes.

Top module: `ja_elastic_fifo`

## Requirements
- R1: `size_sel` selects the usable depth: 2'b01 gives 16 bits, 2'b10 gives 32 bits, 2'b11 gives 128 bits, and 2'b00 disables the attenuator.
- R2: With `path_rx` = 1 the store sits in the receive path and `tx_dout` equals `tx_din` combinationally. With `path_rx` = 0 the store sits in the transmit path and `rx_dout` equals `rx_din` combinationally.
- R3: A write strobe on the selected path stores its input bit. Each `rd_stb` moves the oldest stored bit onto the selected path's output at the next clock edge, and the output holds until the next read. Bits come out in the order they were written.
- R4: After the first clock edge following reset release, and on the edge after any change of `size_sel` or `path_rx`, the store holds depth/2 zero bits and the alarm is 0. Strobes in the cycle that triggers the recentring are dropped.
- R5: With `size_sel` = 2'b00, both outputs equal their inputs combinationally, the alarm is held at 0, and strobes have no effect.
- R6: The alarm is set on the clock edge at which the fill level becomes 2 or less, or becomes depth-2 or more.
- R7: Once set, the alarm stays at 1 until a status read, even when the fill level moves back toward the centre.
- R8: A `status_rd` pulse while enabled clears the alarm to 0 and recentres the store to depth/2 zero bits on the next edge.
- R9: A write to a full store is discarded. A read from an empty store drives 0 on the output and leaves the fill level at 0.
- R10: When write and read strobes arrive in the same cycle and the store is neither full nor empty, both complete and the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| size_sel | input | 2 | Depth / enable selection |
| path_rx | input | 1 | 1 = attenuate receive path, 0 = attenuate transmit path |
| tx_din | input | 1 | Transmit serial input bit |
| tx_wr | input | 1 | Transmit write strobe (line clock enable) |
| rx_din | input | 1 | Receive serial input bit |
| rx_wr | input | 1 | Receive write strobe (line clock enable) |
| rd_stb | input | 1 | Dejittered read strobe |
| status_rd | input | 1 | Alarm status read pulse; clears alarm and recentres |
| tx_dout | output | 1 | Transmit serial output bit |
| rx_dout | output | 1 | Receive serial output bit |
| limit_alarm | output | 1 | Latched near-full / near-empty alarm |

## Verification
The bench drives the fill level to exactly depth-2 and to exactly 2 at each of the three depths. A design with an off-by-one threshold, or one that ignores the size field, raises the alarm one write early, one write late, or at the wrong depth. It also drains the store past empty and writes past full, using bit patterns chosen so that a design which advances a pointer on an empty read, or overwrites the oldest slot on a full write, shows a wrong bit in a later read. Further cases cover the alarm staying latched as the level moves back toward the centre, clear-on-read, combinational bypass when disabled, and the choice of steered path. A design that got these wrong would drop the alarm early, keep stale data after a clear, or route the buffered bits to the wrong output.

// File: rtl/ja_pkg.sv
package ja_pkg;
  typedef enum logic [1:0] {
    JA_OFF  = 2'b00,
    JA_D16  = 2'b01,
    JA_D32  = 2'b10,
    JA_D128 = 2'b11
  } ja_size_e;
endpackage

// File: rtl/ja_path_steer.sv
module ja_path_steer (
  input  logic enabled,
  input  logic path_rx,
  input  logic tx_din,
  input  logic tx_wr,
  input  logic rx_din,
  input  logic rx_wr,
  input  logic fifo_bit,
  output logic fifo_din,
  output logic fifo_wr,
  output logic tx_dout,
  output logic rx_dout
);
  logic use_rx;
  logic use_tx;

  assign use_rx   = enabled && path_rx;
  assign use_tx   = enabled && !path_rx;
  assign fifo_din = path_rx ? rx_din : tx_din;
  assign fifo_wr  = path_rx ? rx_wr  : tx_wr;
  assign tx_dout  = use_tx ? fifo_bit : tx_din;
  assign rx_dout  = use_rx ? fifo_bit : rx_din;
endmodule

// File: rtl/ja_fill_track.sv
module ja_fill_track #(
  parameter int FW     = 8,
  parameter int MARGIN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enabled,
  input  logic          clear,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [FW-1:0] depth,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic          alarm
);
  localparam logic [FW-1:0] MG = FW'(MARGIN);

  logic [FW-1:0] fill_q, fill_d;
  logic          alarm_q, alarm_d;
  logic          near_d;

  assign wr_ok = enabled && !clear && wr_req && (fill_q < depth);
  assign rd_ok = enabled && !clear && rd_req && (fill_q != '0);
  assign alarm = alarm_q;

  always_comb begin
    fill_d  = fill_q;
    alarm_d = alarm_q;
    near_d  = 1'b0;
    if (!enabled) begin
      alarm_d = 1'b0;
    end else if (clear) begin
      fill_d  = depth >> 1;
      alarm_d = 1'b0;
    end else begin
      if (wr_ok && !rd_ok) begin
        fill_d = fill_q + 1'b1;
      end else if (rd_ok && !wr_ok) begin
        fill_d = fill_q - 1'b1;
      end
      near_d  = (fill_d <= MG) || (fill_d >= (depth - MG));
      alarm_d = alarm_q | near_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      fill_q  <= fill_d;
      alarm_q <= alarm_d;
    end
  end

  // R9: fill never exceeds the selected depth
  a_r9_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && !clear) |-> (fill_q <= depth));

  // R7: alarm latched until a clear
  a_r7_alarm_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && enabled && !clear) |=> alarm_q);

  // R8: clear recentres and drops alarm
  a_r8_clear_centres: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && enabled) |=> ((fill_q == ($past(depth) >> 1)) && !alarm_q));

  // R10: simultaneous accepted write and read keep the level
  a_r10_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_ok) |=> (fill_q == $past(fill_q)));
endmodule

// File: rtl/ja_bit_store.sv
module ja_bit_store #(
  parameter int MAXD = 128,
  parameter int PW   = 7,
  parameter int FW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [FW-1:0] depth,
  input  logic          wr_ok,
  input  logic          din,
  input  logic          rd_en,
  input  logic          rd_ok,
  output logic          dout
);
  logic [MAXD-1:0] mem_q, mem_d;
  logic [PW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [PW-1:0]   mask, half;
  logic            out_q, out_d;

  assign mask = PW'(depth - 1'b1);
  assign half = PW'(depth >> 1);
  assign dout = out_q;

  always_comb begin
    mem_d = mem_q;
    wp_d  = wp_q;
    rp_d  = rp_q;
    out_d = out_q;
    if (clear) begin
      mem_d = '0;
      rp_d  = '0;
      wp_d  = half;
    end else begin
      if (wr_ok) begin
        mem_d[wp_q] = din;
        wp_d        = (wp_q + 1'b1) & mask;
      end
      if (rd_en) begin
        out_d = rd_ok ? mem_q[rp_q] : 1'b0;
      end
      if (rd_ok) begin
        rp_d = (rp_q + 1'b1) & mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      out_q <= 1'b0;
    end else begin
      mem_q <= mem_d;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      out_q <= out_d;
    end
  end
endmodule

// File: rtl/ja_elastic_fifo.sv
module ja_elastic_fifo
  import ja_pkg::*;
#(
  parameter int DEPTH_S = 16,
  parameter int DEPTH_M = 32,
  parameter int DEPTH_L = 128,
  parameter int MARGIN  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] size_sel,
  input  logic       path_rx,
  input  logic       tx_din,
  input  logic       tx_wr,
  input  logic       rx_din,
  input  logic       rx_wr,
  input  logic       rd_stb,
  input  logic       status_rd,
  output logic       tx_dout,
  output logic       rx_dout,
  output logic       limit_alarm
);
  localparam int PW = $clog2(DEPTH_L);
  localparam int FW = $clog2(DEPTH_L + 1);

  logic [1:0]    rsync_q;
  logic          srst_n;
  logic [2:0]    cfg_q;
  logic          cfg_chg;
  logic          enabled;
  logic          recentre;
  logic [FW-1:0] depth;
  ja_size_e      size_e;
  logic          fifo_din, fifo_wr, fifo_bit;
  logic          wr_ok, rd_ok, rd_en, alarm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cfg_q <= '0;
    else         cfg_q <= {size_sel, path_rx};
  end

  assign size_e   = ja_size_e'(size_sel);
  assign enabled  = (size_e != JA_OFF);
  assign cfg_chg  = ({size_sel, path_rx} != cfg_q);
  assign recentre = enabled && (status_rd || cfg_chg);
  assign rd_en    = enabled && !recentre && rd_stb;

  always_comb begin
    case (size_e)
      JA_D32:  depth = FW'(DEPTH_M);
      JA_D128: depth = FW'(DEPTH_L);
      default: depth = FW'(DEPTH_S);
    endcase
  end

  ja_path_steer u_steer (
    .enabled (enabled),
    .path_rx (path_rx),
    .tx_din  (tx_din),
    .tx_wr   (tx_wr),
    .rx_din  (rx_din),
    .rx_wr   (rx_wr),
    .fifo_bit(fifo_bit),
    .fifo_din(fifo_din),
    .fifo_wr (fifo_wr),
    .tx_dout (tx_dout),
    .rx_dout (rx_dout)
  );

  ja_fill_track #(.FW(FW), .MARGIN(MARGIN)) u_fill (
    .clk    (clk),
    .rst_n  (srst_n),
    .enabled(enabled),
    .clear  (recentre),
    .wr_req (fifo_wr),
    .rd_req (rd_stb),
    .depth  (depth),
    .wr_ok  (wr_ok),
    .rd_ok  (rd_ok),
    .alarm  (alarm)
  );

  ja_bit_store #(.MAXD(DEPTH_L), .PW(PW), .FW(FW)) u_store (
    .clk  (clk),
    .rst_n(srst_n),
    .clear(recentre),
    .depth(depth),
    .wr_ok(wr_ok),
    .din  (fifo_din),
    .rd_en(rd_en),
    .rd_ok(rd_ok),
    .dout (fifo_bit)
  );

  assign limit_alarm = alarm && enabled;

  // R5: bypass keeps both paths transparent and alarm quiet
  a_r5_bypass: assert property (@(posedge clk) disable iff (!srst_n)
    (size_sel == 2'b00) |-> (!limit_alarm && (rx_dout == rx_din) && (tx_dout == tx_din)));
endmodule

// File: tb/tb_ja_elastic_fifo.sv
module tb_ja_elastic_fifo;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] size_sel;
  logic       path_rx;
  logic       tx_din, tx_wr, rx_din, rx_wr, rd_stb, status_rd;
  logic       tx_dout, rx_dout, limit_alarm;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ja_elastic_fifo dut (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .path_rx(path_rx),
    .tx_din(tx_din), .tx_wr(tx_wr), .rx_din(rx_din), .rx_wr(rx_wr),
    .rd_stb(rd_stb), .status_rd(status_rd),
    .tx_dout(tx_dout), .rx_dout(rx_dout), .limit_alarm(limit_alarm)
  );

  // {wr, din, rd, sts, exp_out, exp_alarm}; 16-bit depth, receive path
  localparam logic [5:0] VEC [25] = '{
    6'b110000, 6'b100000, 6'b110000, 6'b110000, 6'b100000,
    6'b110001, 6'b001001, 6'b111001, 6'b000100, 6'b001000,
    6'b001000, 6'b001000, 6'b001000, 6'b001000, 6'b001001,
    6'b001001, 6'b001001, 6'b001001, 6'b110001, 6'b100001,
    6'b001011, 6'b001001, 6'b001001, 6'b110001, 6'b001011
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic cur_out();
    return path_rx ? rx_dout : tx_dout;
  endfunction

  task automatic cyc(input logic wr, input logic din, input logic rd, input logic sts);
    if (path_rx) begin rx_wr = wr; rx_din = din; tx_wr = 1'b0; end
    else         begin tx_wr = wr; tx_din = din; rx_wr = 1'b0; end
    rd_stb = rd; status_rd = sts;
    @(negedge clk);
    rx_wr = 1'b0; tx_wr = 1'b0; rd_stb = 1'b0; status_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; size_sel = 2'b01; path_rx = 1'b1;
    tx_din = 1'b0; tx_wr = 1'b0; rx_din = 1'b0; rx_wr = 1'b0;
    rd_stb = 1'b0; status_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 reset alarm", limit_alarm, 1'b0);
    chk("R4 reset out", rx_dout, 1'b0);
    rst_n = 1'b1;
    idle(4);

    // Table walk: R1 R3 R4 R6 R7 R8 R9 R10, with R2 on the transmit side
    for (int i = 0; i < 25; i++) begin
      tx_din = i[0];
      cyc(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R3/R6 vec %0d out", i), rx_dout, VEC[i][1]);
      chk($sformatf("R6/R7 vec %0d alarm", i), limit_alarm, VEC[i][0]);
      tx_din = ~tx_din; #1;
      chk($sformatf("R2 vec %0d tx pass", i), tx_dout, tx_din);
    end

    // R9: full-store write discarded, empty read gives 0
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 clear alarm", limit_alarm, 1'b0);
    for (int k = 0; k < 9; k++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 16; k++) begin
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      chk($sformatf("R9 drain %0d", k), rx_dout, (k >= 8) ? 1'b1 : 1'b0);
    end
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 empty read", rx_dout, 1'b0);

    // R1/R4: 32-bit depth, alarm on the 14th write
    size_sel = 2'b10;
    idle(1);
    chk("R4 size change clears alarm", limit_alarm, 1'b0);
    for (int k = 0; k < 13; k++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R1 d32 below limit", limit_alarm, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R1 d32 at limit", limit_alarm, 1'b1);

    // R1: 128-bit depth, alarm on the 62nd read
    size_sel = 2'b11;
    idle(1);
    for (int k = 0; k < 61; k++) begin
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      if (k == 0) chk("R4 d128 preload zero", rx_dout, 1'b0);
    end
    chk("R1 d128 above low limit", limit_alarm, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R1 d128 at low limit", limit_alarm, 1'b1);

    // R5: disabled, both paths transparent, alarm held low
    size_sel = 2'b00;
    #1;
    chk("R5 alarm off", limit_alarm, 1'b0);
    for (int k = 0; k < 20; k++) begin
      rx_din = k[0]; tx_din = ~k[0]; rx_wr = 1'b1; rd_stb = k[1];
      @(negedge clk);
      #1;
      chk("R5 rx pass", rx_dout, rx_din);
      chk("R5 tx pass", tx_dout, tx_din);
      chk("R5 alarm held", limit_alarm, 1'b0);
    end
    rx_wr = 1'b0; rd_stb = 1'b0;

    // R2: store moved to the transmit path
    size_sel = 2'b01; path_rx = 1'b0;
    idle(1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 9; k++) begin
      rx_din = k[0];
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R2 tx buffered", cur_out(), (k == 8) ? 1'b1 : 1'b0);
      #1;
      chk("R2 rx pass", rx_dout, rx_din);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule